// File: doc/BRIEF.md
# Packet-Interface Transfer Byte Counter and Host Data Path

This block is the data-transfer datapath of a packet-interface host port that sits between an embedded microcontroller and a PC host. It keeps a 16-bit transfer byte counter that both sides can read and write as two byte-wide registers. It holds a 12-entry byte queue that carries data from the microcontroller to the host. It also decodes the write strobe that starts a transfer. The microcontroller uses a simple register bus with write strobes and side-effect-free reads. The host uses a read/write strobe port. Bytes going into the external buffer memory are counted through a valid/ready handshake.

The host loads a maximum length into the count registers. The microcontroller may then overwrite the count with the size of the remaining packet and start the transfer by writing to the trigger address. While a transfer is active, the counter moves down by one for each unit the transfer direction selects. When it reaches zero, the block pulses a done output and ends the transfer. On the memory handshake, `mem_wready` is high only while a host-to-memory transfer is active with a nonzero count. A byte is counted only in a cycle where both `mem_wvalid` and `mem_wready` are high. The source may hold `mem_wvalid` for as long as it likes.

Register addresses, shared by both sides where they apply:
- 0x80: data queue.
- 0x82: count low byte.
- 0x83: count high byte.
- 0x84: trigger.
- 0x85: control. Only the microcontroller writes this register. Bits [2:0] hold the transfer type and bit 3 holds the direction (1 = host-to-memory, 0 = memory-to-host).

Top module: `xfer_count_path`

## Requirements
- R1: After reset the count is 0, the queue is empty, both sticky flags are 0, no transfer is active, `xfer_done` is 0, and the control register is 0.
- R2: The count low byte (0x82) and high byte (0x83) are written by a write strobe from either side. Both sides read them back, on `mcu_rdata` or `host_rdata`, starting in the cycle after the write.
- R3: When both sides write the same count byte in the same cycle, the microcontroller's value is stored.
- R4: A microcontroller write to 0x84 sets `xfer_active` from the next cycle. The data value written is ignored.
- R5: With direction bit 3 = 0 and a transfer active, each host read of 0x80 lowers the count by one.
- R6: With direction bit 3 = 1, `mem_wready` is high exactly while a transfer is active and the count is nonzero. Each cycle with both `mem_wvalid` and `mem_wready` high lowers the count by one.
- R7: The count never wraps below zero. When a decrement takes it from 1 to 0, `xfer_done` is high for exactly the next cycle and `xfer_active` falls at the same time.
- R8: A direct write to a count byte in the same cycle as a decrement takes effect, and the decrement is dropped.
- R9: With transfer type 3'b101, microcontroller writes to 0x80 enter a 12-byte queue. Host reads of 0x80 return the bytes in write order and remove them. `fifo_level` reports the number held.
- R10: A queue write while 12 bytes are held is dropped, and it sets `fifo_ovf`, which stays set until reset.
- R11: A host read of 0x80 with type 3'b101 and an empty queue returns 0 and leaves the level unchanged. It sets `fifo_udf`, which stays set until reset.
- R12: With any transfer type other than 3'b101, microcontroller writes to 0x80 leave the queue unchanged. Host reads of 0x80 return 0 and remove nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mcu_addr | input | 8 | Microcontroller register address |
| mcu_wr | input | 1 | Microcontroller write strobe |
| mcu_wdata | input | 8 | Microcontroller write data |
| mcu_rdata | output | 8 | Microcontroller read data (combinational on address) |
| host_addr | input | 8 | Host register address |
| host_rd | input | 1 | Host read strobe (consumes queue data at 0x80) |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| mem_wvalid | input | 1 | Buffer memory has a byte being written |
| mem_wready | output | 1 | Block accepts counting of a memory byte |
| xfer_active | output | 1 | Transfer in progress |
| xfer_done | output | 1 | One-cycle pulse when the count reaches zero |
| fifo_level | output | 4 | Bytes held in the queue |
| fifo_ovf | output | 1 | Sticky queue overflow |
| fifo_udf | output | 1 | Sticky queue underflow |

## Verification
A wrong counter value shows on the count readback ports on the very next cycle. It also shows later as a done pulse in the wrong cycle or a `mem_wready` that stays high too long. A corrupted queue pointer or level shows at `fifo_level` at once, and as a wrong byte order on `host_rdata` at the next read of 0x80. The reference model follows every register of the block cycle by cycle, so any divergence is caught in the first cycle it reaches a port.

// File: rtl/xfr_pkg.sv
package xfr_pkg;
  localparam logic [7:0] A_DATA   = 8'h80;
  localparam logic [7:0] A_CNT_LO = 8'h82;
  localparam logic [7:0] A_CNT_HI = 8'h83;
  localparam logic [7:0] A_TRIG   = 8'h84;
  localparam logic [7:0] A_CTRL   = 8'h85;
  localparam logic [2:0] T_MCU_Q  = 3'b101;

  typedef struct packed {
    logic       to_mem;
    logic [2:0] ttype;
  } ctrl_t;
endpackage

// File: rtl/xfr_fifo.sv
module xfr_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 12,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  pdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          ovf,
  output logic          udf
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          full, do_push, do_pop;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr] <= pdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      ovf    <= 1'b0;
      udf    <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
      case ({do_push, do_pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
      if (push && full)  ovf <= 1'b1;
      if (pop && empty)  udf <= 1'b1;
    end
  end
endmodule

// File: rtl/xfr_bytecnt.sv
module xfr_bytecnt #(
  parameter int unsigned BW = 8,
  localparam int unsigned CW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] lo_data,
  input  logic [BW-1:0] hi_data,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          last,
  output logic          done
);
  logic any_wr;
  assign any_wr = wr_lo || wr_hi;
  assign last   = dec && !any_wr && (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (any_wr) begin
        cnt <= {wr_hi ? hi_data : cnt[CW-1:BW], wr_lo ? lo_data : cnt[BW-1:0]};
      end else if (dec && cnt != '0) begin
        cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/xfer_count_path.sv
module xfer_count_path
  import xfr_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 12,
  parameter int unsigned BYTE_W     = 8,
  localparam int unsigned CNT_W     = 2 * BYTE_W,
  localparam int unsigned LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        mcu_addr,
  input  logic              mcu_wr,
  input  logic [BYTE_W-1:0] mcu_wdata,
  output logic [BYTE_W-1:0] mcu_rdata,
  input  logic [7:0]        host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              mem_wvalid,
  output logic              mem_wready,
  output logic              xfer_active,
  output logic              xfer_done,
  output logic [LW-1:0]     fifo_level,
  output logic              fifo_ovf,
  output logic              fifo_udf
);
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              mcu_lo, mcu_hi, host_lo, host_hi;
  logic              q_mode, q_push, q_pop, q_empty, host_dread;
  logic              dec, last, trig;
  logic [BYTE_W-1:0] q_head;

  assign mcu_lo     = mcu_wr  && (mcu_addr  == A_CNT_LO);
  assign mcu_hi     = mcu_wr  && (mcu_addr  == A_CNT_HI);
  assign host_lo    = host_wr && (host_addr == A_CNT_LO);
  assign host_hi    = host_wr && (host_addr == A_CNT_HI);
  assign trig       = mcu_wr  && (mcu_addr  == A_TRIG);
  assign host_dread = host_rd && (host_addr == A_DATA);

  assign q_mode = (ctrl_q.ttype == T_MCU_Q);
  assign q_push = mcu_wr && (mcu_addr == A_DATA) && q_mode;
  assign q_pop  = host_dread && q_mode;

  assign mem_wready = xfer_active && ctrl_q.to_mem && (cnt_q != '0);
  assign dec = xfer_active && (ctrl_q.to_mem ? (mem_wvalid && mem_wready) : host_dread);

  xfr_bytecnt #(.BW(BYTE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_lo   (mcu_lo || host_lo),
    .wr_hi   (mcu_hi || host_hi),
    .lo_data (mcu_lo ? mcu_wdata : host_wdata),
    .hi_data (mcu_hi ? mcu_wdata : host_wdata),
    .dec     (dec),
    .cnt     (cnt_q),
    .last    (last),
    .done    (xfer_done)
  );

  xfr_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .pdata (mcu_wdata),
    .pop   (q_pop),
    .head  (q_head),
    .level (fifo_level),
    .empty (q_empty),
    .ovf   (fifo_ovf),
    .udf   (fifo_udf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      xfer_active <= 1'b0;
    end else begin
      if (mcu_wr && mcu_addr == A_CTRL) ctrl_q <= ctrl_t'(mcu_wdata[3:0]);
      if (trig)      xfer_active <= 1'b1;
      else if (last) xfer_active <= 1'b0;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_DATA:   host_rdata = (q_mode && !q_empty) ? q_head : '0;
      A_CNT_LO: host_rdata = cnt_q[BYTE_W-1:0];
      A_CNT_HI: host_rdata = cnt_q[CNT_W-1:BYTE_W];
      default:  host_rdata = '0;
    endcase
  end

  always_comb begin
    mcu_rdata = '0;
    case (mcu_addr)
      A_CNT_LO: mcu_rdata = cnt_q[BYTE_W-1:0];
      A_CNT_HI: mcu_rdata = cnt_q[CNT_W-1:BYTE_W];
      A_CTRL:   mcu_rdata = BYTE_W'(ctrl_q);
      default:  mcu_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xfr_chk.sv
module xfr_chk
  import xfr_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 12,
  parameter int unsigned LW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   cnt,
  input logic          mcu_wr,
  input logic [7:0]    mcu_addr,
  input logic [7:0]    mcu_wdata,
  input logic          xfer_done,
  input logic          xfer_active,
  input logic          to_mem,
  input logic          mem_wready,
  input logic [LW-1:0] fifo_level,
  input logic          fifo_ovf,
  input logic          fifo_udf
);
  p_done_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> cnt == 16'd0);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
  p_ready_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wready |-> (xfer_active && to_mem && cnt != 16'd0));
  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_wr && mcu_addr == A_CNT_LO) |=> cnt[7:0] == $past(mcu_wdata));
  p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(FIFO_DEPTH));
  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf |=> fifo_ovf);
  p_udf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_udf |=> fifo_udf);
endmodule

bind xfer_count_path xfr_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LW(LW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt         (cnt_q),
  .mcu_wr      (mcu_wr),
  .mcu_addr    (mcu_addr),
  .mcu_wdata   (mcu_wdata),
  .xfer_done   (xfer_done),
  .xfer_active (xfer_active),
  .to_mem      (ctrl_q.to_mem),
  .mem_wready  (mem_wready),
  .fifo_level  (fifo_level),
  .fifo_ovf    (fifo_ovf),
  .fifo_udf    (fifo_udf)
);

// File: tb/sim_xfer_count_path.sv
`timescale 1ns/1ps
module sim_xfer_count_path;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] mcu_addr = 8'h00, mcu_wdata = 8'h00, host_addr = 8'h00, host_wdata = 8'h00;
  logic       mcu_wr = 1'b0, host_rd = 1'b0, host_wr = 1'b0, mem_wvalid = 1'b0;
  logic [7:0] mcu_rdata, host_rdata;
  logic       mem_wready, xfer_active, xfer_done, fifo_ovf, fifo_udf;
  logic [3:0] fifo_level;

  always #4 clk = ~clk;

  xfer_count_path u0 (
    .clk(clk), .rst_n(rst_n),
    .mcu_addr(mcu_addr), .mcu_wr(mcu_wr), .mcu_wdata(mcu_wdata), .mcu_rdata(mcu_rdata),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
    .xfer_active(xfer_active), .xfer_done(xfer_done),
    .fifo_level(fifo_level), .fifo_ovf(fifo_ovf), .fifo_udf(fifo_udf)
  );

  // reference model state
  int         cnt_m;
  bit         act_m, done_m, ovf_m, udf_m;
  int         ctrl_m;
  logic [7:0] q_m[$];
  int         checks = 0, fails = 0;
  string      tag = "R1";

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int rd_model(input logic [7:0] a, input bit host);
    if (a == 8'h82) return cnt_m & 8'hFF;
    if (a == 8'h83) return (cnt_m >> 8) & 8'hFF;
    if (host && a == 8'h80) return ((ctrl_m & 7) == 5 && q_m.size() != 0) ? int'(q_m[0]) : 0;
    if (!host && a == 8'h85) return ctrl_m;
    return 0;
  endfunction

  task automatic model_update();
    bit qmode, hread, ready, dec, wlo, whi, last;
    int lo, hi, pre;
    qmode = (ctrl_m & 7) == 5;
    hread = host_rd && host_addr == 8'h80;
    ready = act_m && ctrl_m[3] && cnt_m != 0;
    dec   = act_m && (ctrl_m[3] ? (mem_wvalid && ready) : hread);
    wlo = (mcu_wr && mcu_addr == 8'h82) || (host_wr && host_addr == 8'h82);
    whi = (mcu_wr && mcu_addr == 8'h83) || (host_wr && host_addr == 8'h83);
    lo = (mcu_wr && mcu_addr == 8'h82) ? mcu_wdata : host_wdata;
    hi = (mcu_wr && mcu_addr == 8'h83) ? mcu_wdata : host_wdata;
    last = dec && !wlo && !whi && cnt_m == 1;
    if (wlo || whi) cnt_m = ((whi ? hi : (cnt_m >> 8)) << 8) | (wlo ? lo : (cnt_m & 8'hFF));
    else if (dec && cnt_m > 0) cnt_m--;
    done_m = last;
    pre = q_m.size();
    if (hread && qmode) begin
      if (pre == 0) udf_m = 1; else void'(q_m.pop_front());
    end
    if (mcu_wr && mcu_addr == 8'h80 && qmode) begin
      if (pre == 12) ovf_m = 1; else q_m.push_back(mcu_wdata);
    end
    if (mcu_wr && mcu_addr == 8'h84) act_m = 1;
    else if (last) act_m = 0;
    if (mcu_wr && mcu_addr == 8'h85) ctrl_m = mcu_wdata & 8'h0F;
  endtask

  task automatic step();
    #1;
    chk("mcu_rdata", mcu_rdata, rd_model(mcu_addr, 0));
    chk("host_rdata", host_rdata, rd_model(host_addr, 1));
    chk("mem_wready", mem_wready, (act_m && ctrl_m[3] && cnt_m != 0) ? 1 : 0);
    chk("xfer_active", xfer_active, act_m);
    chk("xfer_done", xfer_done, done_m);
    chk("fifo_level", fifo_level, q_m.size());
    chk("fifo_ovf", fifo_ovf, ovf_m);
    chk("fifo_udf", fifo_udf, udf_m);
    @(posedge clk);
    model_update();
    @(negedge clk);
    mcu_wr = 0; host_wr = 0; host_rd = 0;
  endtask

  task automatic mwr(input logic [7:0] a, input logic [7:0] d);
    mcu_addr = a; mcu_wdata = d; mcu_wr = 1; step();
  endtask
  task automatic hwr(input logic [7:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1; step();
  endtask
  task automatic hrd(input logic [7:0] a);
    host_addr = a; host_rd = 1; step();
  endtask
  task automatic look(input logic [7:0] ma, input logic [7:0] ha);
    mcu_addr = ma; host_addr = ha; step();
  endtask

  initial begin
    #(8 * 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    cnt_m = 0; act_m = 0; done_m = 0; ovf_m = 0; udf_m = 0; ctrl_m = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    tag = "R1"; look(8'h82, 8'h83); look(8'h85, 8'h80);

    tag = "R2"; hwr(8'h82, 8'h34); hwr(8'h83, 8'h12); look(8'h82, 8'h83);
    mwr(8'h83, 8'h00); look(8'h83, 8'h82);

    tag = "R3";
    mcu_addr = 8'h82; mcu_wdata = 8'h5A; mcu_wr = 1;
    host_addr = 8'h82; host_wdata = 8'hC3; host_wr = 1; step();
    look(8'h82, 8'h82);

    tag = "R12"; mwr(8'h80, 8'h11); hrd(8'h80); look(8'h85, 8'h80);

    tag = "R9"; mwr(8'h85, 8'h05);
    for (int i = 0; i < 12; i++) mwr(8'h80, 8'hA0 + 8'(i));
    tag = "R10"; mwr(8'h80, 8'hEE); look(8'h85, 8'h80); mwr(8'h80, 8'hEF);

    tag = "R4"; mwr(8'h82, 8'h05); mwr(8'h83, 8'h00); mwr(8'h84, 8'hAA); look(8'h82, 8'h80);
    tag = "R5";
    for (int i = 0; i < 4; i++) hrd(8'h80);
    tag = "R7"; hrd(8'h80); look(8'h82, 8'h80);
    for (int i = 0; i < 7; i++) hrd(8'h80);
    tag = "R11"; hrd(8'h80); look(8'h82, 8'h80); hrd(8'h80);

    tag = "R6"; mwr(8'h85, 8'h08); mwr(8'h82, 8'h03); mwr(8'h84, 8'h00);
    mem_wvalid = 1;
    for (int i = 0; i < 5; i++) look(8'h82, 8'h83);
    tag = "R8"; mwr(8'h82, 8'h04); mwr(8'h84, 8'h00); look(8'h82, 8'h82);
    mwr(8'h82, 8'h09); look(8'h82, 8'h82);
    mem_wvalid = 0;
    hwr(8'h83, 8'h01); look(8'h83, 8'h82);
    for (int i = 0; i < 3; i++) begin mem_wvalid = 1; look(8'h82, 8'h83); end
    mem_wvalid = 0; look(8'h82, 8'h83);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule